// File: doc/BRIEF.md
# Conversion Data-Ready Flag Generator

This block drives the active-low data-ready indication of a periodically updating converter and mirrors it as a register status bit. The conversion core marks the start of each output-word update with a one-cycle request. The block then holds an update interval of a fixed number of system-clock cycles. At the end of the interval it emits a load pulse that commits the new word, and the flag falls one cycle later to announce fresh data. Data read while the interval is running are not valid.

How the flag is released depends on the mode. In gate mode the flag goes back high on the first read clock of a data read. When nobody reads, it also goes high for the length of each update interval and falls again afterwards. In pulse mode the flag stays low until a new conversion is started, and reads and updates leave it alone. A separate overrun flag records a read that was still running when an update interval began. The serial port and chip select do not gate any of this logic.

Top module: `drdy_flag_gen`

## Requirements
- R1: After reset, drdy_n and drdy_bit are 1, and update_busy, load_word and overrun are 0.
- R2: An upd_start sampled while update_busy is 0 raises update_busy from the next cycle for exactly UPD_CYCLES cycles (20 by default). An upd_start sampled while update_busy is 1 is ignored and does not stretch the interval.
- R3: load_word is 1 for exactly one cycle, the last cycle of the update interval. drdy_n becomes 0 in the cycle after load_word and never falls at any other time.
- R4: With pulse_mode = 0 (gate mode), a rd_start or conv_start sampled outside a load_word cycle sets drdy_n to 1 in the next cycle.
- R5: With pulse_mode = 0, an accepted upd_start sets drdy_n to 1 in the next cycle. The flag therefore pulses high for the whole interval when no read takes place.
- R6: With pulse_mode = 1, drdy_n is set to 1 only by conv_start. rd_start and upd_start leave it unchanged.
- R7: drdy_bit equals drdy_n in every cycle.
- R8: overrun becomes 1 in the cycle after an accepted upd_start that is sampled with rd_active = 1. It becomes 0 in the cycle after a rd_start, and setting wins when both happen in the same cycle.
- R9: In a load_word cycle, drdy_n becomes 0 in the next cycle even if rd_start or conv_start is sampled in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pulse_mode | input | 1 | 0 = gate mode, 1 = pulse mode |
| upd_start | input | 1 | Pulse from the conversion core: an output-word update begins |
| rd_start | input | 1 | Pulse on the first read clock of a data read |
| rd_active | input | 1 | A data read is in progress |
| conv_start | input | 1 | Start-conversion strobe |
| drdy_n | output | 1 | Active-low data-ready flag |
| drdy_bit | output | 1 | Status-register copy of the data-ready flag |
| update_busy | output | 1 | Update interval in progress; data invalid |
| load_word | output | 1 | One-cycle commit of the new output word |
| overrun | output | 1 | A read overlapped the start of an update interval |

## Verification
The bench targets an upd_start that arrives mid-interval: a design that restarted its counter would stretch update_busy past 20 cycles. A read clock landing on the load cycle is also exercised, where wrong priority would leave the flag high over fresh data. Pulse mode is stimulated with reads and updates that must not release the flag; gate logic leaking into that mode would raise it. A simultaneous overrun set and clear is also covered, and the wrong winner would lose the overrun record.

// File: rtl/drdy_flag_gen.sv
module drdy_flag_gen #(
  parameter int UPD_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse_mode,
  input  logic upd_start,
  input  logic rd_start,
  input  logic rd_active,
  input  logic conv_start,
  output logic drdy_n,
  output logic drdy_bit,
  output logic update_busy,
  output logic load_word,
  output logic overrun
);

  localparam int CW = $clog2(UPD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(UPD_CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          flag_q;
  logic          ovr_q;

  wire accept    = upd_start & ~busy_q;
  wire release_c = conv_start | (~pulse_mode & (rd_start | accept));

  assign load_word   = busy_q & (cnt_q == '0);
  assign update_busy = busy_q;
  assign drdy_n      = flag_q;
  assign drdy_bit    = flag_q;
  assign overrun     = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
    end else if (load_word) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b1;
    else if (load_word) flag_q <= 1'b0;
    else if (release_c) flag_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  ovr_q <= 1'b0;
    else if (accept & rd_active) ovr_q <= 1'b1;
    else if (rd_start)           ovr_q <= 1'b0;
  end

  p_busy_ends_with_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(update_busy) |-> $past(load_word));
  p_busy_ignores_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (update_busy && !load_word) |=> update_busy);
  p_fall_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_word |=> !drdy_n);
  p_fall_only_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drdy_n) |-> $past(load_word));
  p_gate_read_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && rd_start && !load_word) |=> drdy_n);
  p_gate_update_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && upd_start && !update_busy) |=> drdy_n);
  p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !drdy_n && !conv_start) |=> !drdy_n);
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_start && !update_busy && rd_active) |=> overrun);

endmodule

// File: tb/test_drdy_flag_gen.sv
module test_drdy_flag_gen;
  localparam int N = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse_mode = 1'b0, upd_start = 1'b0, rd_start = 1'b0, rd_active = 1'b0, conv_start = 1'b0;
  logic drdy_n, drdy_bit, update_busy, load_word, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  drdy_flag_gen #(.UPD_CYCLES(N)) i_drdy_flag_gen (
    .clk(clk), .rst_n(rst_n), .pulse_mode(pulse_mode), .upd_start(upd_start),
    .rd_start(rd_start), .rd_active(rd_active), .conv_start(conv_start),
    .drdy_n(drdy_n), .drdy_bit(drdy_bit), .update_busy(update_busy),
    .load_word(load_word), .overrun(overrun));

  // behavioural reference: cycles of interval left, flag, overrun
  int m_left = 0;
  bit m_flag = 1;
  bit m_ovr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_flag = 1; m_ovr = 0;
    end else begin
      bit ending, acc;
      ending = (m_left == 1);
      acc = upd_start && (m_left == 0);
      if (ending) m_flag = 0;
      else if (conv_start || (!pulse_mode && (rd_start || acc))) m_flag = 1;
      if (acc && rd_active) m_ovr = 1;
      else if (rd_start) m_ovr = 0;
      if (acc) m_left = N;
      else if (m_left > 0) m_left = m_left - 1;
    end
  end

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(pulse_mode ? "R6 drdy_n" : "R4 R5 drdy_n", drdy_n, m_flag);
      check("R7 drdy_bit", drdy_bit, drdy_n);
      check("R2 update_busy", update_busy, m_left > 0);
      check("R3 load_word", load_word, m_left == 1);
      check("R8 overrun", overrun, m_ovr);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_upd();
    upd_start = 1; tick(1); upd_start = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int busy_len;
    tick(4);
    check("R1 drdy_n", drdy_n, 1'b1);
    check("R1 drdy_bit", drdy_bit, 1'b1);
    check("R1 busy", update_busy, 1'b0);
    check("R1 load", load_word, 1'b0);
    check("R1 overrun", overrun, 1'b0);
    rst_n = 1;
    tick(2);

    // R2: interval length, restart ignored mid-way
    pulse_upd();
    busy_len = 0;
    for (int i = 0; i < N + 5; i++) begin
      if (i == 5) upd_start = 1;
      if (i == 6) upd_start = 0;
      if (update_busy) busy_len++;
      tick(1);
    end
    check("R2 busy length", busy_len == N, 1'b1);
    check("R3 flag low after load", drdy_n, 1'b0);

    // R4: read clock releases in gate mode
    rd_start = 1; tick(1); rd_start = 0;
    check("R4 read release", drdy_n, 1'b1);

    // R5: unread data, flag pulses high during update
    pulse_upd(); tick(N);
    check("R5 low after first update", drdy_n, 1'b0);
    pulse_upd();
    check("R5 high during update", drdy_n, 1'b1);
    tick(N);
    check("R5 low again", drdy_n, 1'b0);

    // R9: read clock on the load cycle
    pulse_upd(); tick(N - 1);
    check("R3 load cycle", load_word, 1'b1);
    rd_start = 1; conv_start = 1; tick(1); rd_start = 0; conv_start = 0;
    check("R9 load wins", drdy_n, 1'b0);

    // R8: overrun set, then simultaneous set/clear, then clear
    rd_active = 1; pulse_upd(); rd_active = 0;
    check("R8 overrun set", overrun, 1'b1);
    tick(N + 1);
    rd_active = 1; rd_start = 1; upd_start = 1; tick(1);
    rd_active = 0; rd_start = 0; upd_start = 0;
    check("R8 set wins", overrun, 1'b1);
    rd_start = 1; tick(1); rd_start = 0;
    check("R8 cleared", overrun, 1'b0);
    tick(N + 2);

    // R6: pulse mode holds until conversion start
    pulse_mode = 1;
    pulse_upd(); tick(N);
    check("R6 low after update", drdy_n, 1'b0);
    rd_start = 1; tick(1); rd_start = 0;
    check("R6 read ignored", drdy_n, 1'b0);
    pulse_upd();
    check("R6 update ignored", drdy_n, 1'b0);
    tick(N + 1);
    conv_start = 1; tick(1); conv_start = 0;
    check("R6 conv releases", drdy_n, 1'b1);
    pulse_mode = 0;

    // mixed stimulus against the reference model
    for (int i = 0; i < 4000; i++) begin
      upd_start  = ($urandom_range(0, 7) == 0);
      rd_start   = ($urandom_range(0, 11) == 0);
      rd_active  = ($urandom_range(0, 3) == 0);
      conv_start = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 199) == 0) pulse_mode = ~pulse_mode;
      tick(1);
    end
    upd_start = 0; rd_start = 0; rd_active = 0; conv_start = 0;
    tick(2);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end
endmodule